// File: doc/BRIEF.md
# Masked Dual-Event Compare Output Port

This block owns an 8-bit output port whose bits are changed in groups by two timer compare events. Two 16-bit compare values are matched against a free-running 16-bit timer supplied from outside. When the timer equals the "raise" compare value, every port bit selected by the raise mask is driven to 1. When the timer equals the "drop" compare value, every port bit selected by the drop mask is driven to 0. Bits outside a mask keep their state, so a single event can move many pins together while leaving others alone.

Software reaches the block through a simple register bus. The bus writes both compare values, both masks and the port itself, and reads back every register together with the live port state. Each compare event also raises its own sticky event flag, which software clears by writing a one to it. A parameter can insert one register stage after the comparators, which moves every event effect one clock later.

Top module: `mcc_port`

## Requirements
- R1: While `rst_n` is low and right after reset, the port, both compare values, both masks and both event flags are 0.
- R2: When `timer` equals the raise compare value (address 0) at a rising clock edge, every port bit whose raise-mask bit (address 2) is 1 becomes 1 after that edge. All other bits are unchanged.
- R3: When `timer` equals the drop compare value (address 1) at a rising clock edge, every port bit whose drop-mask bit (address 3) is 1 becomes 0 after that edge. All other bits are unchanged.
- R4: When both events occur at the same edge, the new port value is (old | raise mask) & ~drop mask, so a bit that is in both masks ends at 0.
- R5: A bus write to the port address (4) loads `bus_wdata[7:0]` into the port. If a compare event occurs at the same edge, the written value wins completely.
- R6: `bus_rdata` reads back combinationally: address 0 and 1 give the 16-bit compare values, 2 and 3 give the masks in bits 7:0, 4 gives the port state in bits 7:0, and 5 gives the flags (bit 0 raise, bit 1 drop). Addresses 6 and 7 read 0, and unused high bits read 0.
- R7: Compare registers store all 16 written bits. Mask and port registers store only `bus_wdata[7:0]`.
- R8: A raise or drop event sets flag bit 0 or 1, and the flag stays set until a write to address 5 with a 1 in that bit position. An event at the same edge as the clearing write leaves the flag set. `irq_raise` and `irq_drop` show flag bits 0 and 1.
- R9: With no event and no port write, the port holds its value.
- R10: A compare value written at an edge takes part in matching from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for write and read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| timer | input | 16 | Timer count to compare against |
| port_out | output | 8 | Port state |
| irq_raise | output | 1 | Sticky raise-event flag |
| irq_drop | output | 1 | Sticky drop-event flag |

## Verification
Two pairs of functions can land on the same edge: the raise and drop events, and a compare event together with a direct software write to the port. The bench sets both compare values equal, so that a single timer value fires both events together. It also raises the bus write strobe in the same cycle as a matching timer value. Over a sweep of mask and port patterns, the result is judged against (old | raise) & ~drop and against the written byte. Flag clearing colliding with a new event is provoked the same way.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] ADR_RAISE_CMP = 3'd0;
   localparam logic [ADDR_W-1:0] ADR_DROP_CMP  = 3'd1;
   localparam logic [ADDR_W-1:0] ADR_RAISE_MSK = 3'd2;
   localparam logic [ADDR_W-1:0] ADR_DROP_MSK  = 3'd3;
   localparam logic [ADDR_W-1:0] ADR_PORT      = 3'd4;
   localparam logic [ADDR_W-1:0] ADR_FLAGS     = 3'd5;
   localparam int N_EVT  = 2;
   localparam int EV_RAISE = 0;
   localparam int EV_DROP  = 1;
endpackage

// File: rtl/mcc_cmp.sv
module mcc_cmp #(
   parameter int TW   = 16,
   parameter int PIPE = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] timer,
   input  logic [TW-1:0] value,
   output logic          hit
);
   logic eq;
   assign eq = (timer == value);

   initial assert (PIPE == 0 || PIPE == 1) else $error("PIPE must be 0 or 1");

   generate
      if (PIPE == 1) begin : g_reg
         logic hit_q;
         always_ff @(posedge clk) begin
            if (!rst_n) hit_q <= 1'b0;
            else        hit_q <= eq;
         end
         assign hit = hit_q;
      end else begin : g_comb
         assign hit = eq;
      end
   endgenerate
endmodule

// File: rtl/mcc_regs.sv
module mcc_regs
   import mcc_pkg::*;
#(
   parameter int TW = 16,
   parameter int PW = 8,
   parameter int DW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DW-1:0]        wdata,
   input  logic [N_EVT-1:0]     hits,
   input  logic [PW-1:0]        port_q,
   output logic [TW-1:0]        cmp_val [N_EVT],
   output logic [PW-1:0]        raise_msk,
   output logic [PW-1:0]        drop_msk,
   output logic [N_EVT-1:0]     flags,
   output logic                 port_wr,
   output logic [DW-1:0]        rdata
);
   initial assert (DW >= TW && DW >= PW && DW >= N_EVT) else $error("bus too narrow");

   logic [N_EVT-1:0] flag_clr;

   assign port_wr  = wr && (addr == ADR_PORT);
   assign flag_clr = (wr && addr == ADR_FLAGS) ? wdata[N_EVT-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_val[EV_RAISE] <= '0;
         cmp_val[EV_DROP]  <= '0;
         raise_msk         <= '0;
         drop_msk          <= '0;
      end else if (wr) begin
         case (addr)
            ADR_RAISE_CMP: cmp_val[EV_RAISE] <= wdata[TW-1:0];
            ADR_DROP_CMP:  cmp_val[EV_DROP]  <= wdata[TW-1:0];
            ADR_RAISE_MSK: raise_msk         <= wdata[PW-1:0];
            ADR_DROP_MSK:  drop_msk          <= wdata[PW-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~flag_clr) | hits;
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADR_RAISE_CMP: rdata[TW-1:0]    = cmp_val[EV_RAISE];
         ADR_DROP_CMP:  rdata[TW-1:0]    = cmp_val[EV_DROP];
         ADR_RAISE_MSK: rdata[PW-1:0]    = raise_msk;
         ADR_DROP_MSK:  rdata[PW-1:0]    = drop_msk;
         ADR_PORT:      rdata[PW-1:0]    = port_q;
         ADR_FLAGS:     rdata[N_EVT-1:0] = flags;
         default:       rdata            = '0;
      endcase
   end

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      hits[EV_RAISE] |=> flags[EV_RAISE]);                                 // R8
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[EV_DROP] && !flag_clr[EV_DROP]) |=> flags[EV_DROP]);          // R8
endmodule

// File: rtl/mcc_outport.sv
module mcc_outport #(
   parameter int PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          raise_hit,
   input  logic          drop_hit,
   input  logic [PW-1:0] raise_msk,
   input  logic [PW-1:0] drop_msk,
   input  logic          sw_wr,
   input  logic [PW-1:0] sw_data,
   output logic [PW-1:0] port_q
);
   initial assert (PW >= 1) else $error("port width must be positive");

   logic [PW-1:0] up_bits, dn_bits, evt_next;

   assign up_bits  = raise_hit ? raise_msk : '0;
   assign dn_bits  = drop_hit  ? drop_msk  : '0;
   assign evt_next = (port_q | up_bits) & ~dn_bits;

   always_ff @(posedge clk) begin
      if (!rst_n)     port_q <= '0;
      else if (sw_wr) port_q <= sw_data;
      else            port_q <= evt_next;
   end

   AST_RAISE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (raise_hit && !drop_hit && !sw_wr) |=> ((port_q & $past(raise_msk)) == $past(raise_msk)));  // R2
   AST_DROP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_hit && !sw_wr) |=> ((port_q & $past(drop_msk)) == '0));        // R4
   AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr |=> (port_q == $past(sw_data)));                               // R5
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_wr && !raise_hit && !drop_hit) |=> $stable(port_q));            // R9
endmodule

// File: rtl/mcc_port.sv
module mcc_port
   import mcc_pkg::*;
#(
   parameter int TW   = 16,
   parameter int PW   = 8,
   parameter int DW   = 16,
   parameter int PIPE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic [TW-1:0]     timer,
   output logic [PW-1:0]     port_out,
   output logic              irq_raise,
   output logic              irq_drop
);
   logic [TW-1:0]    cmp_val [N_EVT];
   logic [N_EVT-1:0] hits;
   logic [N_EVT-1:0] flags;
   logic [PW-1:0]    raise_msk, drop_msk, port_q;
   logic             port_wr;

   mcc_regs #(.TW(TW), .PW(PW), .DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .hits(hits), .port_q(port_q), .cmp_val(cmp_val), .raise_msk(raise_msk),
      .drop_msk(drop_msk), .flags(flags), .port_wr(port_wr), .rdata(bus_rdata)
   );

   for (genvar e = 0; e < N_EVT; e++) begin : g_cmp
      mcc_cmp #(.TW(TW), .PIPE(PIPE)) u_cmp (
         .clk(clk), .rst_n(rst_n), .timer(timer), .value(cmp_val[e]), .hit(hits[e])
      );
   end

   mcc_outport #(.PW(PW)) u_out (
      .clk(clk), .rst_n(rst_n), .raise_hit(hits[EV_RAISE]), .drop_hit(hits[EV_DROP]),
      .raise_msk(raise_msk), .drop_msk(drop_msk), .sw_wr(port_wr),
      .sw_data(bus_wdata[PW-1:0]), .port_q(port_q)
   );

   assign port_out  = port_q;
   assign irq_raise = flags[EV_RAISE];
   assign irq_drop  = flags[EV_DROP];

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (port_out == '0 && !irq_raise && !irq_drop));             // R1
endmodule

// File: tb/mcc_port_test.sv
`timescale 1ns/1ps
module mcc_port_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [15:0] timer = 16'hFFFF;
   logic [7:0]  port_out;
   logic        irq_raise, irq_drop;

   localparam logic [15:0] IDLE = 16'hFFFF;
   localparam logic [15:0] RV   = 16'h1234;
   localparam logic [15:0] DV   = 16'h0ABC;

   int nvec = 0;
   int nbad = 0;
   bit done = 0;

   mcc_port uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer(timer),
      .port_out(port_out), .irq_raise(irq_raise), .irq_drop(irq_drop)
   );

   always #4 clk = ~clk;

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      nvec++;
      if (got !== exp) begin
         nbad++;
         $display("FAIL %s got=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic pulse(input logic [15:0] t);
      timer = t;
      @(negedge clk);
      timer = IDLE;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         nvec++; nbad++;
         $display("FAIL watchdog got=hung expected=finish");
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      logic [15:0] r;
      repeat (3) @(negedge clk);
      // R1: state during reset
      chk("R1 port", {8'h0, port_out}, 16'h0);
      chk("R1 irq", {14'h0, irq_raise, irq_drop}, 16'h0);
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), r);
         chk("R1 reg", r, 16'h0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 port after release", {8'h0, port_out}, 16'h0);

      // R7 / R6 register storage and readback
      wr(3'd0, RV);  rd(3'd0, r); chk("R7 raise cmp", r, RV);
      wr(3'd1, DV);  rd(3'd1, r); chk("R7 drop cmp", r, DV);
      wr(3'd2, 16'hABCD); rd(3'd2, r); chk("R7 raise mask", r, 16'h00CD);
      wr(3'd3, 16'h5A3C); rd(3'd3, r); chk("R7 drop mask", r, 16'h003C);
      wr(3'd4, 16'hFF96); rd(3'd4, r); chk("R6 port read", r, 16'h0096);
      chk("R6 port pin", {8'h0, port_out}, 16'h0096);
      rd(3'd6, r); chk("R6 unused 6", r, 16'h0);
      rd(3'd7, r); chk("R6 unused 7", r, 16'h0);

      // sweep of mask and port patterns
      for (int i = 0; i < 24; i++) begin
         logic [7:0] s, c, p, w;
         s = 8'(i * 37 + 5);
         c = 8'(i * 91 + 3);
         p = 8'(i * 53 + 17);
         w = 8'(i * 29 + 101);
         wr(3'd2, {8'h0, s});
         wr(3'd3, {8'h0, c});
         wr(3'd4, {8'h0, p});
         chk("R5 port write", {8'h0, port_out}, {8'h0, p});
         pulse(RV);
         chk("R2 raise", {8'h0, port_out}, {8'h0, p | s});
         wr(3'd4, {8'h0, p});
         pulse(DV);
         chk("R3 drop", {8'h0, port_out}, {8'h0, p & ~c});
         wr(3'd4, {8'h0, p});
         pulse(16'h5555);
         chk("R9 no event hold", {8'h0, port_out}, {8'h0, p});
         // both events at once
         wr(3'd1, RV);
         wr(3'd4, {8'h0, p});
         pulse(RV);
         chk("R4 both events", {8'h0, port_out}, {8'h0, (p | s) & ~c});
         wr(3'd1, DV);
         // software write collides with an event
         wr(3'd4, {8'h0, p});
         bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = {8'h0, w};
         timer = (i % 2 == 0) ? RV : DV;
         @(negedge clk);
         bus_wr = 1'b0; timer = IDLE;
         chk("R5 write beats event", {8'h0, port_out}, {8'h0, w});
      end

      // R10: new compare value used only from the next edge
      wr(3'd2, 16'h00FF);
      wr(3'd4, 16'h0000);
      bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h0777; timer = 16'h0777;
      @(negedge clk);
      bus_wr = 1'b0; timer = IDLE;
      chk("R10 same-edge value not used", {8'h0, port_out}, 16'h0000);
      pulse(16'h0777);
      chk("R10 next edge value used", {8'h0, port_out}, 16'h00FF);
      wr(3'd0, RV);

      // R8 sticky flags
      wr(3'd5, 16'h0003);
      rd(3'd5, r); chk("R8 flags cleared", r, 16'h0);
      pulse(RV);
      repeat (3) @(negedge clk);
      rd(3'd5, r); chk("R8 raise sticky", r, 16'h0001);
      chk("R8 irq_raise", {15'h0, irq_raise}, 16'h1);
      pulse(DV);
      rd(3'd5, r); chk("R8 both flags", r, 16'h0003);
      chk("R8 irq_drop", {15'h0, irq_drop}, 16'h1);
      wr(3'd5, 16'h0001);
      rd(3'd5, r); chk("R8 clear raise only", r, 16'h0002);
      bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 16'h0002; timer = DV;
      @(negedge clk);
      bus_wr = 1'b0; timer = IDLE;
      rd(3'd5, r); chk("R8 event beats clear", r, 16'h0002);
      wr(3'd5, 16'h0002);
      rd(3'd5, r); chk("R8 drop cleared", r, 16'h0000);

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule